// File: doc/BRIEF.md
# Boot-time clock configuration sequencer

This block brings the board clock chips to a working setup before the main system clock runs. It is clocked from a free-running boot oscillator. It waits for that oscillator to be declared usable, then reads a configuration image from a byte-addressed nonvolatile store over a simple request/response read port. Two marker bytes at the start of the image decide whether the image is trusted. A module-presence code and a three-bit switch value pick one of seven configurations. For each of three target chips, the block then walks that configuration's list of register address/data pairs and hands each pair to the chip's own serial write channel, one write at a time.

The three targets are a reference clock buffer, a sampling clock buffer and a PLL on the plug-in clock module. The order is fixed: all reference-buffer writes, then all sampling-buffer writes, then the PLL writes. When the image markers do not match, the block takes its write lists from small tables that it computes internally instead of from the image. Once the last write has been acknowledged, a clocks-invalid status output falls. Downstream clock managers use that output as their reset release.

The bus transport to the nonvolatile store, the serial shifting toward the chips and any checking of register contents are left to neighbouring blocks.

Top module: `boot_clk_sequencer`

## Requirements
- R1: After reset, and while `bootClkValid` is low, the block issues no read request (`memReq` = 0) and no write request (`wrReq` = 0), and `clocksInvalid` stays 1. The configuration inputs are sampled once, on the cycle in which the block leaves idle.
- R2: The first two reads go to byte addresses IMAGE_BASE (15000) and IMAGE_BASE+1. The image is trusted only when these bytes are 0xA5 and 0xCD, in that order.
- R3: Configuration index: module code 00 or 11 gives 0. Module code 01 decodes `cfgSwitch[1:0]` only: 01 gives 1, 10 gives 2, 00 gives 3, and 11 gives 0. Module code 10 decodes all three switch bits: 101 gives 4, 110 gives 5, 111 gives 6, and any other value gives 0.
- R4: With a trusted image, the pair k of configuration c for the reference buffer is read at 15002 + 16c + 2k (address byte) and the following byte (data byte). At most 8 pairs are read.
- R5: The sampling buffer uses 15130 + 16c + 2k, with at most 8 pairs. The PLL uses 15258 + 80s + 2k, with at most 40 pairs, where slot s is 0 for configuration 0 and c-3 for configurations 4 to 6. Configurations 1 to 3 produce no PLL writes.
- R6: Each pair produces exactly one write. `wrReq` is one-hot: bit 0 is the reference buffer, bit 1 the sampling buffer and bit 2 the PLL. The request stays high with stable `wrAddr`/`wrData` until the matching `wrDone` bit is seen.
- R7: Writes come out in device order (reference, sampling, PLL) and in pair order within a device. A read request and a write request are never active together.
- R8: An address byte of 0xFF ends that device's list at once, with no write for that slot. A list also ends after its maximum pair count.
- R9: When the image is not trusted, no further reads take place. Each device gets 2 default pairs, and k = 0 or 1 gives address 16·(d+1)+k and data 16·c+k (d = 0, 1, 2 in device order). PLL defaults exist only for configurations 0 and 4 to 6.
- R10: `clocksInvalid` is 1 until the last write is acknowledged and then stays 0. After that, no read or write requests are made.
- R11: Address and data bytes from the image are passed through unchanged, whatever their values (for example, address 0x00 with data 0xFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running boot clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bootClkValid | input | 1 | Boot clock qualifier; sequencing starts when high |
| moduleType | input | 2 | Clock-module presence/type code |
| cfgSwitch | input | 3 | Clock-module configuration switches |
| memReq | output | 1 | Read request to the nonvolatile store, held until the response |
| memAddr | output | 16 | Byte address of the requested read |
| memRdValid | input | 1 | Read response valid; completes the pending request |
| memRdData | input | 8 | Read response byte |
| wrReq | output | 3 | Per-device register write request, one-hot |
| wrAddr | output | 8 | Register address of the current write |
| wrData | output | 8 | Register data of the current write |
| wrDone | input | 3 | Per-device write completion |
| clocksInvalid | output | 1 | High until all configuration writes have completed |

## Verification
The bench builds the block with its default parameters: image base 15000, 8-pair buffer lists, 40-pair PLL lists and 2 default pairs. With these values it exercises the real image layout, a PLL list run to its full length, and both the image and the fallback paths. Across separate runs it changes the read latency and the write completion latency, so that held requests, back-to-back reads and zero-wait handshakes all occur. The cases cover early list termination, an empty list, pass-through of extreme byte values, and switch codes that fall back to configuration 0.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  typedef enum logic [1:0] {
    RD_MARK0     = 2'd0,
    RD_MARK1     = 2'd1,
    RD_PAIR_ADDR = 2'd2,
    RD_PAIR_DATA = 2'd3
  } rdKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    clrAll;
    logic    capMark0;
    logic    capMark1;
    logic    capAddr;
    logic    capData;
    logic    advPair;
    logic    advDev;
    logic    wrActive;
    rdKind_e rdKind;
  } seqCtl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic imageOk;
    logic allDone;
    logic devHasList;
    logic addrEnd;
    logic pairLast;
    logic wrDoneSel;
  } seqStat_t;

  localparam logic [7:0] MARK_FIRST  = 8'hA5;
  localparam logic [7:0] MARK_SECOND = 8'hCD;
  localparam logic [7:0] END_ADDR    = 8'hFF;

  // configuration index: 0 none, 1..3 coax module A/B/C, 4..6 PLL module A/B/C
  function automatic logic [2:0] decodeCfg(input logic [1:0] modType, input logic [2:0] sw);
    logic [2:0] idx;
    idx = 3'd0;
    case (modType)
      2'b01: begin
        case (sw[1:0])
          2'b01:   idx = 3'd1;
          2'b10:   idx = 3'd2;
          2'b00:   idx = 3'd3;
          default: idx = 3'd0;
        endcase
      end
      2'b10: begin
        case (sw)
          3'b101:  idx = 3'd4;
          3'b110:  idx = 3'd5;
          3'b111:  idx = 3'd6;
          default: idx = 3'd0;
        endcase
      end
      default: idx = 3'd0;
    endcase
    return idx;
  endfunction

endpackage

// File: rtl/cfgseq_datapath.sv
module cfgseq_datapath
  import cfgseq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int IMAGE_BASE  = 15000,
  parameter int RF_OFS      = 2,
  parameter int SAMP_OFS    = 130,
  parameter int PLL_OFS     = 258,
  parameter int SMALL_PAIRS = 8,
  parameter int PLL_PAIRS   = 40,
  parameter int DEF_PAIRS   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  output seqStat_t          stat,
  input  logic [1:0]        moduleType,
  input  logic [2:0]        cfgSwitch,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memRdData,
  output logic [2:0]        wrReq,
  output logic [7:0]        wrAddr,
  output logic [7:0]        wrData,
  input  logic [2:0]        wrDone
);

  localparam int SMALL_STRIDE = 2 * SMALL_PAIRS;
  localparam int PLL_STRIDE   = 2 * PLL_PAIRS;
  localparam int MAX_PAIRS    = (PLL_PAIRS > SMALL_PAIRS) ? PLL_PAIRS : SMALL_PAIRS;
  localparam int PAIR_W       = $clog2(MAX_PAIRS + 1);
  localparam int IDX_W        = (PAIR_W < 4) ? 4 : PAIR_W;

  logic [2:0]        cfgSel;
  logic              markOk0, markOk1;
  logic [1:0]        devIdx;
  logic [IDX_W-1:0]  pairIdx;
  logic [7:0]        regAddr, regData;

  logic [2:0]        pllSlot;
  logic              isCoaxCfg;
  logic [ADDR_W-1:0] regionBase, pairOfs;
  logic [7:0]        defAddr, defData, srcByte;
  logic [IDX_W-1:0]  lastIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgSel  <= '0;
      markOk0 <= 1'b0;
      markOk1 <= 1'b0;
      devIdx  <= '0;
      pairIdx <= '0;
      regAddr <= '0;
      regData <= '0;
    end else begin
      if (ctl.clrAll) begin
        cfgSel  <= decodeCfg(moduleType, cfgSwitch);
        markOk0 <= 1'b0;
        markOk1 <= 1'b0;
        devIdx  <= '0;
        pairIdx <= '0;
      end
      if (ctl.capMark0) markOk0 <= (memRdData == MARK_FIRST);
      if (ctl.capMark1) markOk1 <= (memRdData == MARK_SECOND);
      if (ctl.capAddr)  regAddr <= srcByte;
      if (ctl.capData)  regData <= srcByte;
      if (ctl.advDev) begin
        devIdx  <= devIdx + 2'd1;
        pairIdx <= '0;
      end else if (ctl.advPair) begin
        pairIdx <= pairIdx + 1'b1;
      end
    end
  end

  always_comb begin
    isCoaxCfg = (cfgSel >= 3'd1) && (cfgSel <= 3'd3);
    pllSlot   = (cfgSel >= 3'd4) ? (cfgSel - 3'd3) : 3'd0;
    pairOfs   = ADDR_W'({pairIdx, 1'b0});
    case (devIdx)
      2'd0:    regionBase = ADDR_W'(IMAGE_BASE + RF_OFS)   + ADDR_W'(cfgSel)  * ADDR_W'(SMALL_STRIDE);
      2'd1:    regionBase = ADDR_W'(IMAGE_BASE + SAMP_OFS) + ADDR_W'(cfgSel)  * ADDR_W'(SMALL_STRIDE);
      default: regionBase = ADDR_W'(IMAGE_BASE + PLL_OFS)  + ADDR_W'(pllSlot) * ADDR_W'(PLL_STRIDE);
    endcase
    case (ctl.rdKind)
      RD_MARK0:     memAddr = ADDR_W'(IMAGE_BASE);
      RD_MARK1:     memAddr = ADDR_W'(IMAGE_BASE + 1);
      RD_PAIR_ADDR: memAddr = regionBase + pairOfs;
      default:      memAddr = regionBase + pairOfs + ADDR_W'(1);
    endcase
    // built-in defaults when the image is not trusted
    defAddr = (pairIdx >= IDX_W'(DEF_PAIRS)) ? END_ADDR
                                             : {2'b00, devIdx + 2'd1, pairIdx[3:0]};
    defData = {1'b0, cfgSel, pairIdx[3:0]};
    if (stat.imageOk) srcByte = memRdData;
    else              srcByte = (ctl.rdKind == RD_PAIR_DATA) ? defData : defAddr;
    lastIdx = (devIdx == 2'd2) ? IDX_W'(PLL_PAIRS - 1) : IDX_W'(SMALL_PAIRS - 1);
  end

  always_comb begin
    stat.imageOk    = markOk0 && markOk1;
    stat.allDone    = (devIdx == 2'd3);
    stat.devHasList = !((devIdx == 2'd2) && isCoaxCfg);
    stat.addrEnd    = (regAddr == END_ADDR);
    stat.pairLast   = (pairIdx == lastIdx);
    case (devIdx)
      2'd0:    stat.wrDoneSel = wrDone[0];
      2'd1:    stat.wrDoneSel = wrDone[1];
      2'd2:    stat.wrDoneSel = wrDone[2];
      default: stat.wrDoneSel = 1'b0;
    endcase
  end

  assign wrReq  = ctl.wrActive ? (3'b001 << devIdx) : 3'b000;
  assign wrAddr = regAddr;
  assign wrData = regData;

endmodule

// File: rtl/cfgseq_control.sv
module cfgseq_control
  import cfgseq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     bootClkValid,
  input  logic     memRdValid,
  input  seqStat_t stat,
  output seqCtl_t  ctl,
  output logic     memReq,
  output logic     clocksInvalid
);

  typedef enum logic [3:0] {
    S_IDLE, S_MARK0, S_MARK1, S_DEV, S_GETA, S_CHKA, S_GETD, S_WRITE, S_DONE
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    ctl.rdKind = RD_MARK0;
    memReq    = 1'b0;
    case (state)
      S_IDLE: begin
        if (bootClkValid) begin
          ctl.clrAll = 1'b1;
          nextState  = S_MARK0;
        end
      end
      S_MARK0: begin
        memReq = 1'b1;
        if (memRdValid) begin
          ctl.capMark0 = 1'b1;
          nextState    = S_MARK1;
        end
      end
      S_MARK1: begin
        ctl.rdKind = RD_MARK1;
        memReq     = 1'b1;
        if (memRdValid) begin
          ctl.capMark1 = 1'b1;
          nextState    = S_DEV;
        end
      end
      S_DEV: begin
        if (stat.allDone)          nextState  = S_DONE;
        else if (!stat.devHasList) ctl.advDev = 1'b1;
        else                       nextState  = S_GETA;
      end
      S_GETA: begin
        ctl.rdKind = RD_PAIR_ADDR;
        memReq     = stat.imageOk;
        if (!stat.imageOk || memRdValid) begin
          ctl.capAddr = 1'b1;
          nextState   = S_CHKA;
        end
      end
      S_CHKA: begin
        if (stat.addrEnd) begin
          ctl.advDev = 1'b1;
          nextState  = S_DEV;
        end else begin
          nextState  = S_GETD;
        end
      end
      S_GETD: begin
        ctl.rdKind = RD_PAIR_DATA;
        memReq     = stat.imageOk;
        if (!stat.imageOk || memRdValid) begin
          ctl.capData = 1'b1;
          nextState   = S_WRITE;
        end
      end
      S_WRITE: begin
        ctl.wrActive = 1'b1;
        if (stat.wrDoneSel) begin
          if (stat.pairLast) begin
            ctl.advDev = 1'b1;
            nextState  = S_DEV;
          end else begin
            ctl.advPair = 1'b1;
            nextState   = S_GETA;
          end
        end
      end
      S_DONE:  nextState = S_DONE;
      default: nextState = S_IDLE;
    endcase
  end

  assign clocksInvalid = (state != S_DONE);

endmodule

// File: rtl/boot_clk_sequencer.sv
module boot_clk_sequencer
  import cfgseq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int IMAGE_BASE  = 15000,
  parameter int RF_OFS      = 2,
  parameter int SAMP_OFS    = 130,
  parameter int PLL_OFS     = 258,
  parameter int SMALL_PAIRS = 8,
  parameter int PLL_PAIRS   = 40,
  parameter int DEF_PAIRS   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bootClkValid,
  input  logic [1:0]        moduleType,
  input  logic [2:0]        cfgSwitch,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRdValid,
  input  logic [7:0]        memRdData,
  output logic [2:0]        wrReq,
  output logic [7:0]        wrAddr,
  output logic [7:0]        wrData,
  input  logic [2:0]        wrDone,
  output logic              clocksInvalid
);

  seqCtl_t  ctl;
  seqStat_t stat;

  cfgseq_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .bootClkValid (bootClkValid),
    .memRdValid   (memRdValid),
    .stat         (stat),
    .ctl          (ctl),
    .memReq       (memReq),
    .clocksInvalid(clocksInvalid)
  );

  cfgseq_datapath #(
    .ADDR_W     (ADDR_W),
    .IMAGE_BASE (IMAGE_BASE),
    .RF_OFS     (RF_OFS),
    .SAMP_OFS   (SAMP_OFS),
    .PLL_OFS    (PLL_OFS),
    .SMALL_PAIRS(SMALL_PAIRS),
    .PLL_PAIRS  (PLL_PAIRS),
    .DEF_PAIRS  (DEF_PAIRS)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .stat      (stat),
    .moduleType(moduleType),
    .cfgSwitch (cfgSwitch),
    .memAddr   (memAddr),
    .memRdData (memRdData),
    .wrReq     (wrReq),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .wrDone    (wrDone)
  );

endmodule

// File: rtl/cfgseq_checker.sv
module cfgseq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       bootClkValid,
  input logic       memReq,
  input logic [2:0] wrReq,
  input logic [7:0] wrAddr,
  input logic [7:0] wrData,
  input logic [2:0] wrDone,
  input logic       clocksInvalid
);

  logic sawBootValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             sawBootValid <= 1'b0;
    else if (bootClkValid) sawBootValid <= 1'b1;
  end

  // R1: no reads before the boot clock qualifier has been seen
  assert_idle_until_valid_R1: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> sawBootValid);

  // R6: at most one device channel requested
  assert_one_target_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrReq));

  // R6: request and payload held until the matching completion
  assert_hold_until_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((|wrReq) && !(|(wrReq & wrDone))) |=>
      (wrReq == $past(wrReq)) && $stable(wrAddr) && $stable(wrData));

  // R7: reads and writes never overlap
  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && (|wrReq)));

  // R8: the end marker never reaches a device
  assert_no_end_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|wrReq) |-> (wrAddr != 8'hFF));

  // R10: status stays low once it has fallen
  assert_status_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    !clocksInvalid |=> !clocksInvalid);

  // R10: nothing happens after completion
  assert_quiet_after_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    !clocksInvalid |-> (!memReq && (wrReq == 3'b000)));

endmodule

bind boot_clk_sequencer cfgseq_checker u_checker (
  .clk          (clk),
  .rstN         (rstN),
  .bootClkValid (bootClkValid),
  .memReq       (memReq),
  .wrReq        (wrReq),
  .wrAddr       (wrAddr),
  .wrData       (wrData),
  .wrDone       (wrDone),
  .clocksInvalid(clocksInvalid)
);

// File: tb/boot_clk_sequencer_tb.sv
module boot_clk_sequencer_tb;

  localparam int BASE     = 15000;
  localparam int IMG_SIZE = 578;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bootClkValid = 1'b0;
  logic [1:0]  moduleType = 2'b00;
  logic [2:0]  cfgSwitch = 3'b000;
  logic        memReq;
  logic [15:0] memAddr;
  logic        memRdValid = 1'b0;
  logic [7:0]  memRdData = 8'h00;
  logic [2:0]  wrReq;
  logic [7:0]  wrAddr, wrData;
  logic [2:0]  wrDone = 3'b000;
  logic        clocksInvalid;

  always #4 clk = ~clk;

  boot_clk_sequencer u_dut (
    .clk(clk), .rstN(rstN), .bootClkValid(bootClkValid),
    .moduleType(moduleType), .cfgSwitch(cfgSwitch),
    .memReq(memReq), .memAddr(memAddr), .memRdValid(memRdValid), .memRdData(memRdData),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData), .wrDone(wrDone),
    .clocksInvalid(clocksInvalid)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] img [0:IMG_SIZE-1];
  int expDev[$];
  int expA[$];
  int expD[$];
  int readLog[$];
  bit running = 1'b0;
  int memLat = 0, wrLat = 0, mcnt = 0, wcnt = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // configuration index per R3
  function automatic int modelCfg(input logic [1:0] mt, input logic [2:0] sw);
    if (mt == 2'b01) begin
      if (sw[1:0] == 2'b01) return 1;
      if (sw[1:0] == 2'b10) return 2;
      if (sw[1:0] == 2'b00) return 3;
      return 0;
    end
    if (mt == 2'b10) begin
      if (sw == 3'b101) return 4;
      if (sw == 3'b110) return 5;
      if (sw == 3'b111) return 6;
      return 0;
    end
    return 0;
  endfunction

  // expected write list per R4, R5, R8, R9, R11
  task automatic buildExpected(input int cfg, input bit valid);
    expDev.delete(); expA.delete(); expD.delete();
    for (int d = 0; d < 3; d++) begin
      int base;
      int maxp;
      if (d == 2 && cfg >= 1 && cfg <= 3) continue;
      if (d == 0)      base = 2 + cfg * 16;
      else if (d == 1) base = 130 + cfg * 16;
      else             base = 258 + ((cfg == 0) ? 0 : cfg - 3) * 80;
      maxp = (d == 2) ? 40 : 8;
      for (int k = 0; k < maxp; k++) begin
        int a;
        int v;
        if (valid) begin
          a = img[base + 2 * k];
          v = img[base + 2 * k + 1];
        end else begin
          a = (k >= 2) ? 255 : 16 * (d + 1) + k;
          v = 16 * cfg + k;
        end
        if (a == 255) break;
        expDev.push_back(d);
        expA.push_back(a);
        expD.push_back(v);
      end
    end
  endtask

  // responders and per-clock comparison, all at the falling edge
  always @(negedge clk) begin
    if (running) begin
      if (memReq) begin
        if (mcnt == memLat) begin
          int off;
          off = int'(memAddr) - BASE;
          readLog.push_back(int'(memAddr));
          if (off >= 0 && off < IMG_SIZE) memRdData = img[off];
          else begin
            memRdData = 8'h00;
            check(1'b0, "R4", "read address in image", int'(memAddr), BASE);
          end
          memRdValid = 1'b1;
          mcnt = 0;
        end else begin
          memRdValid = 1'b0;
          mcnt++;
        end
      end else begin
        memRdValid = 1'b0;
        mcnt = 0;
      end

      if (wrReq != 3'b000) begin
        if (wcnt == wrLat) begin
          int dev;
          dev = (wrReq == 3'b001) ? 0 : (wrReq == 3'b010) ? 1 : (wrReq == 3'b100) ? 2 : -1;
          check(dev >= 0, "R6", "write request one-hot", int'(wrReq), 1);
          if (expA.size() == 0) begin
            check(1'b0, "R10", "write after list exhausted", int'(wrAddr), -1);
          end else begin
            check(dev == expDev[0], "R7", "write target order", dev, expDev[0]);
            check(int'(wrAddr) == expA[0], "R4/R11", "write address byte", int'(wrAddr), expA[0]);
            check(int'(wrData) == expD[0], "R5/R11", "write data byte", int'(wrData), expD[0]);
            void'(expDev.pop_front()); void'(expA.pop_front()); void'(expD.pop_front());
          end
          wrDone = wrReq;
          wcnt = 0;
        end else begin
          wrDone = 3'b000;
          wcnt++;
        end
      end else begin
        wrDone = 3'b000;
        wcnt = 0;
      end

      if (expA.size() != 0)
        check(clocksInvalid == 1'b1, "R10", "status high while writes pending", clocksInvalid, 1);
    end
  end

  task automatic fillImage();
    for (int i = 0; i < IMG_SIZE; i++) img[i] = 8'((i * 13 + 1) % 128);
    img[0] = 8'hA5;
    img[1] = 8'hCD;
  endtask

  task automatic runCase(input string name, input logic [1:0] mt, input logic [2:0] sw,
                         input int mlat, input int wlat);
    bit valid;
    int cfg;
    int waitCnt;
    $display("case %s", name);
    @(negedge clk);
    rstN = 1'b0;
    bootClkValid = 1'b0;
    moduleType = mt;
    cfgSwitch = sw;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(clocksInvalid == 1'b1, "R1", "reset status", clocksInvalid, 1);
    check(memReq == 1'b0 && wrReq == 3'b000, "R1", "reset requests", {memReq, wrReq}, 0);

    valid = (img[0] == 8'hA5) && (img[1] == 8'hCD);
    cfg = modelCfg(mt, sw);
    buildExpected(cfg, valid);
    readLog.delete();
    memLat = mlat;
    wrLat = wlat;
    mcnt = 0;
    wcnt = 0;
    running = 1'b1;

    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      check(!memReq && wrReq == 3'b000 && clocksInvalid, "R1", "idle before qualifier",
            {memReq, wrReq, clocksInvalid}, 1);
    end
    bootClkValid = 1'b1;

    waitCnt = 0;
    while (clocksInvalid && waitCnt < 20000) begin
      @(negedge clk);
      waitCnt++;
    end
    check(expA.size() == 0, "R7", "all writes issued before status fell", expA.size(), 0);
    check(readLog.size() >= 2, "R2", "marker reads made", readLog.size(), 2);
    if (readLog.size() >= 2) begin
      check(readLog[0] == BASE, "R2", "first marker address", readLog[0], BASE);
      check(readLog[1] == BASE + 1, "R2", "second marker address", readLog[1], BASE + 1);
    end
    if (!valid)
      check(readLog.size() == 2, "R9", "no image reads on fallback", readLog.size(), 2);

    repeat (12) @(negedge clk);
    check(clocksInvalid == 1'b0, "R10", "status stays low", clocksInvalid, 0);
    running = 1'b0;
    bootClkValid = 1'b0;
  endtask

  initial begin
    fillImage();
    // R9: second marker wrong, no module -> defaults of configuration 0
    img[1] = 8'hCC;
    runCase("fallback none", 2'b00, 3'b000, 0, 0);

    // R4 R8 R11: coax module B, reference list ends at pair 3, extreme values pass through
    fillImage();
    img[2 + 2 * 16 + 6] = 8'hFF;
    img[130 + 2 * 16]     = 8'h00;
    img[130 + 2 * 16 + 1] = 8'hFF;
    runCase("image coax B", 2'b01, 3'b010, 2, 1);

    // R5 R8: PLL module C, empty sampling list, full 40-pair PLL list
    fillImage();
    img[130 + 6 * 16] = 8'hFF;
    runCase("image pll C", 2'b10, 3'b111, 1, 3);

    // R9: first marker wrong, PLL module A -> defaults including PLL
    fillImage();
    img[0] = 8'h00;
    runCase("fallback pll A", 2'b10, 3'b101, 0, 0);

    // R3 R8: module code 11 -> configuration 0, PLL list ends at pair 2
    fillImage();
    img[258 + 4] = 8'hFF;
    runCase("image code 11", 2'b11, 3'b101, 1, 0);

    // R3: coax module with unused switch code -> configuration 0
    fillImage();
    runCase("image coax bad switch", 2'b01, 3'b011, 0, 2);

    // R3: coax module ignores switch bit 2 -> configuration 1
    fillImage();
    runCase("image coax A", 2'b01, 3'b101, 0, 0);

    // R3: PLL module with unused code -> configuration 0
    fillImage();
    runCase("image pll bad switch", 2'b10, 3'b011, 3, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule